// File: doc/BRIEF.md
# Paged Segmented Address Translator

This block turns a 24-bit virtual byte address into an 18-bit physical main-memory address. The address carries a segment number, a page number within the segment and a byte offset. The page size is chosen per request: large pages hold 4,096 bytes and small pages hold 2,048 bytes. An internal page map always has 512 entries, so the virtual space is 2 MB with large pages and 1 MB with small pages. Only segments 0 to 7 of the 32 that the segment field can name are backed by map entries.

Each map entry holds a frame number and a resident flag. Software loads the entries through a one-entry-per-cycle write port. A request strobe starts a lookup, and one cycle later the block returns one of three results: a physical address, a segment exception, or a page fault together with the failing page index. The block skips translation for I/O requests, for addresses whose top (direct) bit is set, and whenever translation is disabled. The sequencing of page traffic to and from backing store is left to the surrounding system.

Top module: `xlat_top`

## Requirements
- R1: While reset is active and in the cycle after it, `rsp_valid` is low and every result output is zero, and all resident flags are clear, so a translated lookup made before any map write reports a page fault.
- R2: `rsp_valid` is high in exactly the cycle after a cycle in which `req` was high. While `rsp_valid` is low, `paddr`, `page_fault`, `seg_exc` and `fault_idx` are all zero.
- R3: Large-page mode (`small_pg`=0) decodes the segment from vaddr[22:18], the page from vaddr[17:12] and the offset from vaddr[11:0]. The physical address is {frame[5:0], vaddr[11:0]}.
- R4: Small-page mode (`small_pg`=1) decodes the segment from vaddr[21:17], the page from vaddr[16:11] and the offset from vaddr[10:0]. vaddr[22] is ignored, and the physical address is {frame[6:0], vaddr[10:0]}.
- R5: The map entry used is index {segment[2:0], page}, which is the same index in both modes. Index 511 is segment 7, page 63.
- R6: A translated request whose segment number is 8 or above returns `seg_exc`=1, `page_fault`=0, `paddr`=0 and `fault_idx`=0.
- R7: A translated request to an entry whose resident flag is clear returns `page_fault`=1, `fault_idx` set to the entry index and `paddr`=0. A successful translation returns both flags and `fault_idx` as zero.
- R8: When `io_req`=1, vaddr[23]=1 or `xlat_en`=0, the request is passed through untranslated: `paddr` is vaddr[17:0] and no flag is raised, whatever the map holds.
- R9: A write with `map_we`=1 stores `map_frame` and `map_res` at `map_idx` for use by later lookups. A lookup in the same cycle as a write to its own entry sees the entry's previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Lookup strobe |
| vaddr | input | 24 | Virtual address; bit 23 is the direct bit |
| small_pg | input | 1 | 1 selects 2 KB pages |
| io_req | input | 1 | I/O request; always bypasses translation |
| xlat_en | input | 1 | Translation enable |
| map_we | input | 1 | Page map write enable |
| map_idx | input | 9 | Page map write index |
| map_frame | input | 7 | Frame number to store |
| map_res | input | 1 | Resident flag to store |
| rsp_valid | output | 1 | Result valid, one cycle after `req` |
| paddr | output | 18 | Physical address |
| page_fault | output | 1 | Entry not resident |
| seg_exc | output | 1 | Segment number out of range |
| fault_idx | output | 9 | Index of the faulting entry |

## Verification
The assertions check the following on every cycle: the one-cycle valid timing, the quiet outputs while idle, that no response carries both flags, that a fault returns a zero address, that the segment exception is raised for out-of-range segments in either mode, and that bypassed requests return their own low address bits. Only the bench scenarios can show that the frame bits are placed correctly in each page mode. The same holds for the index formed at the map boundary, for stale-read behaviour when a write and a lookup hit the same entry in one cycle, and for a resident entry later being marked absent. The bench checks these against its own model of the map.

// File: rtl/xlat_pkg.sv
// Shared widths for the address translator.
// Assumes one direct bit above the segment field and a physical address
// one bit narrower than the large-page frame plus offset would allow.
package xlat_pkg;
    parameter int SEG_W    = 5;
    parameter int PG_W     = 6;
    parameter int OFF_W    = 12;
    parameter int SEG_IMPL = 8;
    parameter int PA_W     = 18;
    localparam int VA_W     = SEG_W + PG_W + OFF_W + 1;
    localparam int SEGSEL_W = $clog2(SEG_IMPL);
    localparam int IDX_W    = SEGSEL_W + PG_W;
    localparam int FRM_W    = PA_W - OFF_W + 1;
endpackage

// File: rtl/xlat_decode.sv
// Splits a virtual address into segment, page and offset for the selected
// page size. Purely combinational. In small-page mode the offset's top bit
// is returned as zero.
module xlat_decode
    import xlat_pkg::*;
(
    input  logic [VA_W-1:0]  vaddr,
    input  logic             small_pg,
    output logic [SEG_W-1:0] seg,
    output logic [PG_W-1:0]  page,
    output logic [OFF_W-1:0] off,
    output logic             direct
);
    localparam int BIG_PG_LO  = OFF_W;
    localparam int BIG_SEG_LO = OFF_W + PG_W;
    localparam int SML_PG_LO  = OFF_W - 1;
    localparam int SML_SEG_LO = OFF_W - 1 + PG_W;

    // field selection by page size
    always_comb begin
        direct = vaddr[VA_W-1];
        if (small_pg) begin
            seg  = vaddr[SML_SEG_LO +: SEG_W];
            page = vaddr[SML_PG_LO +: PG_W];
            off  = {1'b0, vaddr[OFF_W-2:0]};
        end else begin
            seg  = vaddr[BIG_SEG_LO +: SEG_W];
            page = vaddr[BIG_PG_LO +: PG_W];
            off  = vaddr[OFF_W-1:0];
        end
    end
endmodule

// File: rtl/xlat_map.sv
// Page map storage: a frame number per entry plus a resident flag.
// Resident flags clear on reset; frame numbers do not reset. The read is
// asynchronous, so a same-cycle write is seen only from the next cycle.
module xlat_map #(
    parameter int IDX_W = 9,
    parameter int FRM_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [FRM_W-1:0] wframe,
    input  logic             wres,
    input  logic [IDX_W-1:0] ridx,
    output logic [FRM_W-1:0] rframe,
    output logic             rres
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0] res_q;
    logic [FRM_W-1:0] frame_q [DEPTH];

    // resident flags: cleared by reset, set/cleared by writes
    always_ff @(posedge clk) begin
        if (!rst_n)  res_q <= '0;
        else if (we) res_q[widx] <= wres;
    end

    // frame numbers: written only, never reset
    always_ff @(posedge clk) begin
        if (we) frame_q[widx] <= wframe;
    end

    assign rframe = frame_q[ridx];
    assign rres   = res_q[ridx];
endmodule

// File: rtl/xlat_top.sv
// Paged segmented address translator top. A lookup strobed on req
// produces a registered result one cycle later. Assumes callers hold
// request inputs valid only in the strobe cycle.
module xlat_top
    import xlat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [VA_W-1:0]  vaddr,
    input  logic             small_pg,
    input  logic             io_req,
    input  logic             xlat_en,
    input  logic             map_we,
    input  logic [IDX_W-1:0] map_idx,
    input  logic [FRM_W-1:0] map_frame,
    input  logic             map_res,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  paddr,
    output logic             page_fault,
    output logic             seg_exc,
    output logic [IDX_W-1:0] fault_idx
);
    logic [SEG_W-1:0] seg;
    logic [PG_W-1:0]  page;
    logic [OFF_W-1:0] off;
    logic             direct;
    logic [IDX_W-1:0] idx;
    logic [FRM_W-1:0] rframe;
    logic             rres;
    logic             bypass, seg_bad;
    logic [PA_W-1:0]  pa_xl;

    xlat_decode u_dec (
        .vaddr(vaddr), .small_pg(small_pg),
        .seg(seg), .page(page), .off(off), .direct(direct)
    );

    xlat_map #(.IDX_W(IDX_W), .FRM_W(FRM_W)) u_map (
        .clk(clk), .rst_n(rst_n),
        .we(map_we), .widx(map_idx), .wframe(map_frame), .wres(map_res),
        .ridx(idx), .rframe(rframe), .rres(rres)
    );

    // bypass, range check, index and translated address
    always_comb begin
        bypass  = io_req | direct | ~xlat_en;
        seg_bad = seg >= SEG_W'(SEG_IMPL);
        idx     = {seg[SEGSEL_W-1:0], page};
        if (small_pg) pa_xl = {rframe, off[OFF_W-2:0]};
        else          pa_xl = {rframe[FRM_W-2:0], off};
    end

    // result register: one outcome per strobe, zero when idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            paddr      <= '0;
            page_fault <= 1'b0;
            seg_exc    <= 1'b0;
            fault_idx  <= '0;
        end else begin
            rsp_valid  <= req;
            paddr      <= '0;
            page_fault <= 1'b0;
            seg_exc    <= 1'b0;
            fault_idx  <= '0;
            if (req) begin
                if (bypass)        paddr <= vaddr[PA_W-1:0];
                else if (seg_bad)  seg_exc <= 1'b1;
                else if (!rres) begin
                    page_fault <= 1'b1;
                    fault_idx  <= idx;
                end else           paddr <= pa_xl;
            end
        end
    end
endmodule

// File: rtl/xlat_chk.sv
// Protocol checker for xlat_top, attached by bind. Observes ports only.
module xlat_chk
    import xlat_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             req,
    input logic [VA_W-1:0]  vaddr,
    input logic             small_pg,
    input logic             io_req,
    input logic             xlat_en,
    input logic             rsp_valid,
    input logic [PA_W-1:0]  paddr,
    input logic             page_fault,
    input logic             seg_exc,
    input logic [IDX_W-1:0] fault_idx
);
    localparam int BIG_HI = VA_W - 2;
    localparam int SML_HI = VA_W - 3;
    logic passthru, seg_high;
    // independent view of bypass and segment range from the raw address
    always_comb begin
        passthru = io_req || vaddr[VA_W-1] || !xlat_en;
        seg_high = small_pg ? (vaddr[SML_HI -: (SEG_W-SEGSEL_W)] != '0)
                            : (vaddr[BIG_HI -: (SEG_W-SEGSEL_W)] != '0);
    end

    a_r2_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> rsp_valid);
    a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !rsp_valid);
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (paddr == '0 && !page_fault && !seg_exc && fault_idx == '0));
    a_r6_single_flag: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !(seg_exc && page_fault));
    a_r7_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_exc || page_fault) |-> paddr == '0);
    a_r7_clean_idx: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !page_fault) |-> fault_idx == '0);
    a_r8_bypass_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (req && passthru) |=> (!seg_exc && !page_fault && paddr == $past(vaddr[PA_W-1:0])));
    a_r6_seg_range: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !passthru && seg_high) |=> (seg_exc && !page_fault));
endmodule

bind xlat_top xlat_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req(req), .vaddr(vaddr), .small_pg(small_pg),
    .io_req(io_req), .xlat_en(xlat_en), .rsp_valid(rsp_valid), .paddr(paddr),
    .page_fault(page_fault), .seg_exc(seg_exc), .fault_idx(fault_idx)
);

// File: tb/tb_xlat_top.sv
`timescale 1ns/1ps
module tb_xlat_top;
    logic clk = 0, rst_n = 0;
    logic req = 0, small_pg = 0, io_req = 0, xlat_en = 0;
    logic [23:0] vaddr = '0;
    logic map_we = 0, map_res = 0;
    logic [8:0] map_idx = '0;
    logic [6:0] map_frame = '0;
    logic rsp_valid, page_fault, seg_exc;
    logic [17:0] paddr;
    logic [8:0] fault_idx;

    int compared = 0, mismatched = 0;
    logic exp_v = 0, started = 0, done = 0;

    typedef struct { logic [17:0] pa; logic pf; logic se; logic [8:0] fi; string tag; } exp_t;
    exp_t q[$];
    logic [6:0] m_fr [512];
    logic       m_res [512];

    always #4 clk = ~clk;

    xlat_top dut (
        .clk(clk), .rst_n(rst_n), .req(req), .vaddr(vaddr), .small_pg(small_pg),
        .io_req(io_req), .xlat_en(xlat_en), .map_we(map_we), .map_idx(map_idx),
        .map_frame(map_frame), .map_res(map_res), .rsp_valid(rsp_valid),
        .paddr(paddr), .page_fault(page_fault), .seg_exc(seg_exc), .fault_idx(fault_idx)
    );

    function automatic exp_t model(logic [23:0] va, logic sm, logic io, logic xe, string tag);
        exp_t e;
        logic [4:0] sg;
        logic [5:0] pg;
        logic [8:0] ix;
        e.pa = '0; e.pf = 0; e.se = 0; e.fi = '0; e.tag = tag;
        if (io || va[23] || !xe) begin
            e.pa = va[17:0];
        end else begin
            sg = sm ? va[21:17] : va[22:18];
            pg = sm ? va[16:11] : va[17:12];
            if (sg >= 5'd8) e.se = 1;
            else begin
                ix = {sg[2:0], pg};
                if (!m_res[ix]) begin e.pf = 1; e.fi = ix; end
                else e.pa = sm ? {m_fr[ix], va[10:0]} : {m_fr[ix][5:0], va[11:0]};
            end
        end
        return e;
    endfunction

    // driver: one strobe per call, optional same-cycle map write
    task automatic issue(input logic [23:0] va, input logic sm, input logic io,
                         input logic xe, input string tag, input logic we = 0,
                         input logic [8:0] wi = '0, input logic [6:0] wf = '0,
                         input logic wr = 0);
        @(negedge clk);
        req = 1; vaddr = va; small_pg = sm; io_req = io; xlat_en = xe;
        map_we = we; map_idx = wi; map_frame = wf; map_res = wr;
        q.push_back(model(va, sm, io, xe, tag));
        if (we) begin m_fr[wi] = wf; m_res[wi] = wr; end
    endtask

    task automatic map_write(input logic [8:0] wi, input logic [6:0] wf, input logic wr);
        @(negedge clk);
        req = 0; map_we = 1; map_idx = wi; map_frame = wf; map_res = wr;
        m_fr[wi] = wf; m_res[wi] = wr;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req = 0; map_we = 0; io_req = 0;
        end
    endtask

    function automatic logic [23:0] va_big(int sg, int pg, int off);
        return 24'((sg << 18) | (pg << 12) | off);
    endfunction
    function automatic logic [23:0] va_sml(int sg, int pg, int off);
        return 24'((sg << 17) | (pg << 11) | off);
    endfunction

    // expected valid tracks the strobe seen at each edge
    always @(posedge clk) exp_v <= rst_n ? req : 1'b0;

    // monitor: valid timing and scoreboard comparison
    always @(negedge clk) begin
        if (rst_n && started) begin
            compared++;
            if (rsp_valid !== exp_v) begin
                mismatched++;
                $display("FAIL R2 valid: actual %0b expected %0b", rsp_valid, exp_v);
            end
            if (!rsp_valid) begin
                compared++;
                if (paddr !== '0 || page_fault || seg_exc || fault_idx !== '0) begin
                    mismatched++;
                    $display("FAIL R2 idle outputs: actual pa=%h pf=%b se=%b fi=%0d expected zeros",
                             paddr, page_fault, seg_exc, fault_idx);
                end
            end else if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                compared++;
                if (paddr !== e.pa || page_fault !== e.pf || seg_exc !== e.se || fault_idx !== e.fi) begin
                    mismatched++;
                    $display("FAIL %s: actual pa=%h pf=%b se=%b fi=%0d expected pa=%h pf=%b se=%b fi=%0d",
                             e.tag, paddr, page_fault, seg_exc, fault_idx, e.pa, e.pf, e.se, e.fi);
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < 512; i++) begin m_res[i] = 0; m_fr[i] = '0; end
        repeat (3) @(negedge clk);
        compared++;
        if (rsp_valid !== 0 || paddr !== '0) begin
            mismatched++;
            $display("FAIL R1 reset: actual v=%b pa=%h expected v=0 pa=0", rsp_valid, paddr);
        end
        @(negedge clk); rst_n = 1; started = 1;
        idle(1);
        // R1 / R7: nothing resident after reset
        issue(va_big(0, 5, 12'h123), 0, 0, 1, "R1 fault after reset");
        issue(va_big(7, 63, 0), 0, 0, 1, "R7 fault idx 511");
        idle(1);
        // R3 / R5: large-page translation
        map_write(9'd202, 7'h55, 1);
        map_write(9'd511, 7'h7F, 1);
        map_write(9'd0, 7'h01, 1);
        issue(va_big(3, 10, 12'hABC), 0, 0, 1, "R3 large page");
        issue(va_big(7, 63, 12'hFFF), 0, 0, 1, "R5 index 511 large");
        issue(va_big(0, 0, 12'h000), 0, 0, 1, "R5 index 0");
        // R4: small-page, same index; bit 22 ignored
        issue(va_sml(3, 10, 11'h5A5), 1, 0, 1, "R4 small page");
        issue(va_sml(3, 10, 11'h7FF) | 24'h400000, 1, 0, 1, "R4 bit22 ignored");
        issue(va_sml(7, 63, 11'h001), 1, 0, 1, "R5 index 511 small");
        // R6: segment range in both modes
        issue(va_big(8, 0, 0), 0, 0, 1, "R6 seg 8 large");
        issue(va_big(31, 63, 12'hFFF), 0, 0, 1, "R6 seg 31 large");
        issue(va_sml(9, 1, 0), 1, 0, 1, "R6 seg 9 small");
        idle(2);
        // R8: three bypass causes, including an out-of-range segment
        issue(va_big(31, 4, 12'h777) | 24'h800000, 0, 0, 1, "R8 direct bit");
        issue(va_big(5, 4, 12'h321), 0, 1, 1, "R8 io request");
        issue(va_big(6, 2, 12'h0AB), 1, 0, 0, "R8 translation off");
        // R9: clear resident, then same-cycle write sees old value
        map_write(9'd202, 7'h55, 0);
        issue(va_big(3, 10, 12'h001), 0, 0, 1, "R9 entry cleared");
        issue(va_big(2, 2, 12'h010), 0, 0, 1, "R9 same-cycle old", 1, 9'd130, 7'h33, 1);
        issue(va_big(2, 2, 12'h010), 0, 0, 1, "R9 write visible next");
        issue(va_sml(2, 2, 11'h010), 1, 0, 1, "R9 small after write");
        idle(4);
        compared++;
        if (q.size() != 0) begin
            mismatched++;
            $display("FAIL R2 missing responses: actual %0d pending expected 0", q.size());
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL R2 watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule